// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is a bus-master sequencer that moves one aligned operand (one, two or four bytes, read or write) across a 32-bit external data bus. The slave it talks to is not described to it in advance. Each bus cycle ends when the slave returns a two-bit active-low acknowledge code, and that code also tells the controller how wide the slave's port is. When the port is narrower than the bytes still owed, the controller advances the address, re-encodes the remaining size, strobes again and keeps going. One request therefore becomes one, two or four bus cycles.

A request is a single-cycle pulse on `req` while the block is idle. It carries the direction, the size code, the address and (for writes) the operand, right-justified. The controller raises `bus_strobe` for each cycle and keeps it up through any wait states. It drops the strobe for at least one clock between cycles. When the final piece has landed, it pulses `done` for one clock. For reads, the assembled operand then appears on `rd_data`, right-justified in big-endian byte order.

Top module: `dbs_ctrl`

## Requirements
- R1: Under reset and after it, with no request, `bus_strobe`, `busy` and `done` are low.
- R2: While the strobe is high and `ack_n` is 11 (wait), the strobe stays high and `bus_addr`, `bus_size` and `bus_dout` hold their values into the next clock.
- R3: When a slave answers 00 (32-bit port), any operand size completes in exactly one bus cycle.
- R4: When a slave answers 01 (16-bit port) to a long word at address A, the transfer takes two cycles, at A and A+2. The second cycle carries size code 10.
- R5: When a slave answers 10 (8-bit port), each cycle moves one byte and the address steps by one. A long word takes four cycles and a word takes two.
- R6: `req_size` and `bus_size` share one code: 01 is one byte, 10 is two, 11 is three and 00 is four. `bus_size` always gives the number of bytes still untransferred.
- R7: Write data puts the next untransferred byte on bits [31:24], followed by the later bytes in order. With one byte left it is copied to all four lanes. With two left, the pair is copied to both halves. With three left, bits [7:0] repeat the last byte.
- R8: For a port of P bytes, the lane offset is the address modulo P, where lane 0 is [31:24]. Each cycle takes min(remaining, P - offset) bytes starting at that lane. The read result is right-justified, with the first byte most significant and the unused upper bits zero.
- R9: `done` is a one-clock pulse in the clock after the final acknowledge is sampled. `busy` and `bus_strobe` are low while `done` is high.
- R10: After every completing acknowledge, the strobe is low for at least one clock before the next cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start pulse, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (01 byte, 10 word, 00 long) |
| req_addr | input | ADDR_W | Operand address, aligned to its size |
| req_wdata | input | 32 | Write operand, right-justified |
| ack_n | input | 2 | Active-low acknowledge and port-width code |
| bus_din | input | 32 | External read data |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_size | output | 2 | Bytes still owed, coded as req_size |
| bus_strobe | output | 1 | Data strobe, high during a bus cycle |
| bus_read | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_dout | output | 32 | Write data steered onto byte lanes |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read operand |

## Verification
A wrong remaining-byte count shows up on `bus_size` during the very next strobe. It also shows up as a wrong number of bus cycles before `done`, which the bench counts for each port width. A wrong address step or lane offset shows up within one cycle, either as a wrong `bus_addr` or as wrong bytes in the slave's memory model and in `rd_data` once the transfer finishes. A fault in the wait or gap sequencing appears on the strobe itself within one clock of the acknowledge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } dbs_state_e;

    // decoded acknowledge: whether the cycle ends and the port width in bytes
    typedef struct packed {
        logic       fin;
        logic [2:0] pbytes;
    } ack_info_t;

    // size code -> byte count (00 means four)
    function automatic logic [2:0] code_to_bytes(input logic [1:0] code);
        return (code == 2'b00) ? 3'd4 : {1'b0, code};
    endfunction

    // byte count -> size code
    function automatic logic [1:0] bytes_to_code(input logic [2:0] n);
        return n[1:0];
    endfunction

    function automatic ack_info_t decode_ack(input logic [1:0] a_n);
        ack_info_t r;
        unique case (a_n)
            2'b10:   r = '{fin: 1'b1, pbytes: 3'd1};
            2'b01:   r = '{fin: 1'b1, pbytes: 3'd2};
            2'b00:   r = '{fin: 1'b1, pbytes: 3'd4};
            default: r = '{fin: 1'b0, pbytes: 3'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbs_wlanes.sv
module dbs_wlanes
    import dbs_pkg::*;
(
    input  logic [DATA_W-1:0] wbuf,
    input  logic [2:0]        remain,
    output logic [DATA_W-1:0] lanes
);
    // wbuf holds the untransferred bytes left-justified
    always_comb begin
        unique case (remain)
            3'd1:    lanes = {LANES{wbuf[DATA_W-1 -: 8]}};
            3'd2:    lanes = {2{wbuf[DATA_W-1 -: 16]}};
            3'd3:    lanes = {wbuf[DATA_W-1 -: 24], wbuf[DATA_W-17 -: 8]};
            default: lanes = wbuf;
        endcase
    end
endmodule

// File: rtl/dbs_rmerge.sv
module dbs_rmerge
    import dbs_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        addr_lo,
    input  logic [2:0]        remain,
    input  logic [2:0]        pbytes,
    input  logic [DATA_W-1:0] acc,
    output logic [2:0]        take,
    output logic [DATA_W-1:0] acc_next
);
    logic [1:0]        pmask;
    logic [1:0]        off;
    logic [2:0]        room;
    logic [5:0]        sh_off;
    logic [5:0]        sh_keep;
    logic [5:0]        sh_take;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] piece;

    always_comb begin
        pmask   = pbytes[1:0] - 2'd1;
        off     = (pbytes == 3'd1) ? 2'd0 : (addr_lo & pmask);
        room    = pbytes - {1'b0, off};
        take    = (remain < room) ? remain : room;
        sh_off  = {1'b0, off, 3'b000};
        sh_keep = {(3'd4 - take), 3'b000};
        sh_take = {take, 3'b000};
        aligned = din << sh_off;
        piece   = aligned >> sh_keep;
        acc_next = (take == 3'd4) ? piece : ((acc << sh_take) | piece);
    end

    always_comb begin
        if (pbytes != 3'd0 && remain != 3'd0) begin
            assert_take_range_R8: assert (take != 3'd0 && take <= remain && take <= pbytes);
        end
    end
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        ack_n,
    input  logic [31:0]       bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_strobe,
    output logic              bus_read,
    output logic [31:0]       bus_dout,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rd_data
);
    dbs_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        remain_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] rd_q;
    logic              wr_q;
    logic              done_q;

    ack_info_t         ack;
    logic [2:0]        take;
    logic [DATA_W-1:0] acc_next;
    logic              hit;
    logic              last;
    logic [2:0]        req_bytes;
    logic [5:0]        req_sh;
    logic [5:0]        take_sh;

    assign ack       = decode_ack(ack_n);
    assign hit       = (state_q == ST_STROBE) && ack.fin;
    assign last      = (remain_q == take);
    assign req_bytes = code_to_bytes(req_size);
    assign req_sh    = {(3'd4 - req_bytes), 3'b000};
    assign take_sh   = {take, 3'b000};

    dbs_rmerge u_merge (
        .din      (bus_din),
        .addr_lo  (addr_q[1:0]),
        .remain   (remain_q),
        .pbytes   (ack.pbytes),
        .acc      (acc_q),
        .take     (take),
        .acc_next (acc_next)
    );

    dbs_wlanes u_lanes (
        .wbuf   (wbuf_q),
        .remain (remain_q),
        .lanes  (bus_dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            wbuf_q   <= '0;
            acc_q    <= '0;
            rd_q     <= '0;
            wr_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        addr_q   <= req_addr;
                        remain_q <= req_bytes;
                        wbuf_q   <= req_wdata << req_sh;
                        acc_q    <= '0;
                        wr_q     <= req_write;
                        state_q  <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (hit) begin
                        addr_q   <= addr_q + ADDR_W'(take);
                        remain_q <= remain_q - take;
                        wbuf_q   <= wbuf_q << take_sh;
                        acc_q    <= acc_next;
                        if (last) begin
                            if (!wr_q) rd_q <= acc_next;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_GAP:  state_q <= ST_STROBE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_addr   = addr_q;
    assign bus_size   = bytes_to_code(remain_q);
    assign bus_strobe = (state_q == ST_STROBE);
    assign bus_read   = !wr_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign rd_data    = rd_q;

    assert_wait_hold_R2: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && ack_n == 2'b11 |=> bus_strobe && $stable(bus_addr)
            && $stable(bus_size) && $stable(bus_dout));

    assert_gap_R10: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && ack_n != 2'b11 |=> !bus_strobe);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && ack_n != 2'b11 && remain_q != take
            |=> bus_addr == $past(bus_addr) + ADDR_W'($past(take)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_strobe && !busy);

    assert_size_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> remain_q != 3'd0);

endmodule

// File: tb/dbs_ctrl_test.sv
module dbs_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  ack_n = 2'b11;
    logic [31:0] bus_din = '0;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_strobe;
    logic        bus_read;
    logic [31:0] bus_dout;
    logic        busy;
    logic        done;
    logic [31:0] rd_data;

    dbs_ctrl #(.ADDR_W(32)) uut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack_n(ack_n), .bus_din(bus_din), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_strobe(bus_strobe), .bus_read(bus_read),
        .bus_dout(bus_dout), .busy(busy), .done(done), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int ticks = 0;

    // slave model state
    int          pw = 4;
    int          waits = 0;
    logic [7:0]  mem [8];
    int          ncyc = 0;
    logic [31:0] log_addr [8];
    logic [1:0]  log_size [8];
    logic [31:0] log_dout [8];
    int          log_len [8];
    int          viol_gap = 0;
    int          viol_hold = 0;
    int          viol_done = 0;
    bit          gap_due = 0;
    bit          in_cyc = 0;
    int          waitcnt = 0;
    int          slen = 0;
    logic [31:0] cyc_addr = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 8; i++) mem[i] = 8'hA0 + 8'(i);
    endtask

    always @(negedge clk) begin
        ticks++;
        if (ticks > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=0", ticks);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst) begin
            ack_n = 2'b11;
        end else begin
            if (gap_due && bus_strobe) viol_gap++;
            gap_due = 0;
            if (done && bus_strobe) viol_done++;
            if (bus_strobe) begin
                if (!in_cyc) begin
                    in_cyc = 1; cyc_addr = bus_addr; waitcnt = 0; slen = 0;
                end else if (bus_addr !== cyc_addr) viol_hold++;
                slen++;
                if (waitcnt < waits) begin
                    ack_n = 2'b11;
                    waitcnt++;
                end else begin
                    int base, off, rem, n;
                    base = int'(bus_addr[2:0]) & ~(pw - 1);
                    off  = int'(bus_addr[2:0]) - base;
                    rem  = (bus_size == 2'b00) ? 4 : int'(bus_size);
                    n    = (rem < pw - off) ? rem : pw - off;
                    ack_n = (pw == 4) ? 2'b00 : (pw == 2) ? 2'b01 : 2'b10;
                    for (int l = 0; l < 4; l++)
                        bus_din[31 - 8*l -: 8] = (l < pw) ? mem[base + l] : 8'hEE;
                    if (!bus_read)
                        for (int j = 0; j < n; j++)
                            mem[base + off + j] = bus_dout[31 - 8*(off + j) -: 8];
                    if (ncyc < 8) begin
                        log_addr[ncyc] = bus_addr;
                        log_size[ncyc] = bus_size;
                        log_dout[ncyc] = bus_dout;
                        log_len[ncyc]  = slen;
                    end
                    ncyc++;
                    gap_due = 1;
                    in_cyc = 0;
                end
            end else begin
                ack_n = 2'b11;
            end
        end
    end

    task automatic run_op(input logic wr, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] wd);
        int k;
        ncyc = 0;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        k = 0;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk("R9 done seen", {31'd0, done}, 32'd1);
        chk("R9 busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R9 done one clock", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 strobe in reset", {31'd0, bus_strobe}, 32'd0);
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobe idle", {31'd0, bus_strobe}, 32'd0);
        chk("R1 done idle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_port32();
        pw = 4; waits = 0; fill_mem();
        run_op(1'b0, 2'b00, 32'h100, 32'h0);
        chk("R3 long cycles", ncyc, 1);
        chk("R8 long read 32", rd_data, 32'hA0A1A2A3);
        run_op(1'b0, 2'b01, 32'h101, 32'h0);
        chk("R3 byte cycles", ncyc, 1);
        chk("R8 byte lane 1 of 32", rd_data, 32'h000000A1);
        run_op(1'b1, 2'b01, 32'h103, 32'h0000005C);
        chk("R7 byte replicated", log_dout[0], 32'h5C5C5C5C);
        chk("R8 byte write lane 3", {24'd0, mem[3]}, 32'h5C);
        chk("R6 byte size code", {30'd0, log_size[0]}, 32'd1);
    endtask

    task automatic t_port16();
        pw = 2; waits = 0; fill_mem();
        run_op(1'b0, 2'b00, 32'h104, 32'h0);
        chk("R4 long cycles", ncyc, 2);
        chk("R4 second addr", log_addr[1], 32'h106);
        chk("R4 second size", {30'd0, log_size[1]}, 32'd2);
        chk("R8 long read 16", rd_data, 32'hA4A5A6A7);
        run_op(1'b1, 2'b10, 32'h102, 32'h0000BEEF);
        chk("R7 word replicated", log_dout[0], 32'hBEEFBEEF);
        chk("R8 word write 16", {16'd0, mem[2], mem[3]}, 32'hBEEF);
        run_op(1'b0, 2'b01, 32'h105, 32'h0);
        chk("R8 odd byte of 16", rd_data, 32'h000000A5);
    endtask

    task automatic t_port8();
        pw = 1; waits = 0; fill_mem();
        run_op(1'b1, 2'b00, 32'h100, 32'h11223344);
        chk("R5 long cycles", ncyc, 4);
        chk("R6 sizes", {24'd0, log_size[0], log_size[1], log_size[2], log_size[3]}, 32'h000000390 >> 4);
        chk("R5 addr step", log_addr[3], 32'h103);
        chk("R7 three left", log_dout[1], 32'h22334444);
        chk("R7 two left", log_dout[2], 32'h33443344);
        chk("R5 long write 8", {mem[0], mem[1], mem[2], mem[3]}, 32'h11223344);
        run_op(1'b0, 2'b10, 32'h106, 32'h0);
        chk("R5 word cycles", ncyc, 2);
        chk("R8 word read 8", rd_data, 32'h0000A6A7);
    endtask

    task automatic t_waits();
        pw = 2; waits = 3; fill_mem();
        run_op(1'b0, 2'b00, 32'h100, 32'h0);
        chk("R2 strobe length", log_len[0], 4);
        chk("R2 strobe length 2nd", log_len[1], 4);
        chk("R8 read with waits", rd_data, 32'hA0A1A2A3);
        waits = 0;
    endtask

    initial begin
        fill_mem();
        repeat (2) @(negedge clk);
        t_reset();
        t_port32();
        t_port16();
        t_port8();
        t_waits();
        chk("R2 address held", viol_hold, 0);
        chk("R10 gap after ack", viol_gap, 0);
        chk("R9 no strobe with done", viol_done, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule